// File: doc/BRIEF.md
# Shared-Timer Input Debounce Bank

This block filters the inputs of a 32-pin bank so that short glitches and contact bounce never reach the value and interrupt logic behind it. Each raw pin first passes through a reset-cleared synchronizer chain. It then passes through a per-pin filter. The filter moves the pin's clean level to a new value only after the synchronized input has held that value for a programmed number of clock cycles.

Debounce periods are not stored per pin. Three shared timer registers each hold a period in clock cycles. Every pin picks one of them, or none, through a two-bit code. The high bit of that code comes from one select register and the low bit from a second select register, both at the pin's own bit position. Rewriting one timer therefore retunes every pin that uses it at once. Software decides which pins share which timer and converts time to cycles; the block only applies the result.

Configuration arrives over a write-only port: one strobe, a 3-bit address and a data word.

Top module: `shared_debounce_bank`

## Requirements
- R1: After a synchronous reset, all three timer periods, both select registers and every filtered level read zero, so no pin is debounced.
- R2: A raw pin reaches the filter through SYNC_STAGES (default 2) flops. With debouncing off, a raw change shows on `pin_level` SYNC_STAGES+1 clock edges after it is applied.
- R3: A pin's code is {select-high bit, select-low bit} at the pin's index. Code 0 disables filtering for that pin, and codes 1, 2 and 3 select timers 1, 2 and 3.
- R4: A pin whose code is 0, or whose selected timer holds 0, copies its synchronized input to `pin_level` on every edge.
- R5: With a selected period P > 0, the level takes a new value on the edge that ends the P-th consecutive cycle in which the synchronized input differs from the level. Pulses shorter than P cycles leave the level unchanged.
- R6: A return of the synchronized input to the current level clears the pin's count. A train of pulses, each shorter than P and separated by single-cycle returns, never changes the level.
- R7: A write to a timer register takes effect from the next edge for every pin that selects that timer.
- R8: A select write that changes a pin's code clears that pin's count and holds its level on the write edge. The new code applies from the following edge.
- R9: Writes to address 0, 1 and 2 load timers 1, 2 and 3 from the low CNT_W data bits. Address 3 loads the select-high register and address 4 the select-low register. Writes to addresses 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| pin_raw | input | PINS | Unsynchronized pin inputs |
| pin_level | output | PINS | Registered debounced pin levels |

## Verification
The hardest situation to reach is a select-code change that lands while a pin is partway through counting. It must clear the count without moving the level, and the new code must take over only on the next edge. The stimulus reaches it by starting a change on pins tied to the long timer, letting them count for a known number of cycles, and then rewriting the select-high register on a precisely chosen edge. Exact-cycle checks sit on both sides of that edge. The same edge-precise placement is used to hit the last sub-threshold cycle of a debounce window. A long random phase mixes pin toggles with timer and select writes, so timers are retuned under active counting.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int unsigned NUM_TIMERS = 3;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned CODE_W     = 2;

  // Configuration address decode
  localparam logic [ADDR_W-1:0] ADDR_TMR1   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TMR2   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_TMR3   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SEL_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SEL_LO = 3'd4;
endpackage

// File: rtl/dbt_sync.sv
module dbt_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbt_cfg_regs.sv
module dbt_cfg_regs
  import dbt_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0] periods,
  output logic [PINS-1:0]                  sel_hi,
  output logic [PINS-1:0]                  sel_lo,
  output logic [PINS-1:0]                  restart
);
  logic wr_hi, wr_lo;
  assign wr_hi = we && (addr == ADDR_SEL_HI);
  assign wr_lo = we && (addr == ADDR_SEL_LO);

  // Shared timer period registers, one per generate slot
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic [CNT_W-1:0] per_q;
    always_ff @(posedge clk) begin
      if (rst) per_q <= '0;
      else if (we && (addr == ADDR_W'(t))) per_q <= wdata[CNT_W-1:0];
    end
    assign periods[t] = per_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_hi <= '0;
      sel_lo <= '0;
    end else begin
      if (wr_hi) sel_hi <= wdata[PINS-1:0];
      if (wr_lo) sel_lo <= wdata[PINS-1:0];
    end
  end

  // A pin restarts when either of its code bits is about to change
  assign restart = (wr_hi ? (wdata[PINS-1:0] ^ sel_hi) : '0)
                 | (wr_lo ? (wdata[PINS-1:0] ^ sel_lo) : '0);

  // R1: configuration comes out of reset cleared
  a_r1_cfg_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (periods == '0 && sel_hi == '0 && sel_lo == '0));

  // R9: unmapped addresses leave all state untouched
  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && $past(addr) > ADDR_SEL_LO) |->
      (periods == $past(periods) && sel_hi == $past(sel_hi) && sel_lo == $past(sel_lo)));
endmodule

// File: rtl/dbt_pin_filter.sv
module dbt_pin_filter
  import dbt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             samp,
  input  logic [CODE_W-1:0]                code,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0] periods,
  input  logic                             restart,
  output logic                             lvl
);
  logic             prev_q, lvl_q;
  logic [CNT_W-1:0] cnt_q, per_sel, run_nxt;

  // Code 0 means no timer; codes 1..3 select the shared timers
  always_comb begin
    per_sel = '0;
    for (int t = 0; t < NUM_TIMERS; t++)
      if (code == CODE_W'(t + 1)) per_sel = periods[t];
  end

  assign run_nxt = (samp != prev_q) ? CNT_W'(1) : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= samp;
      if (restart) begin
        cnt_q <= '0;
      end else if (per_sel == '0) begin
        lvl_q <= samp;
        cnt_q <= '0;
      end else if (samp == lvl_q) begin
        cnt_q <= '0;
      end else if (run_nxt >= per_sel) begin
        lvl_q <= samp;
        cnt_q <= '0;
      end else begin
        cnt_q <= run_nxt;
      end
    end
  end

  assign lvl = lvl_q;

  // R5: the level only ever moves to the value the input had
  a_r5_moves_to_input: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(samp)));

  // R8: a code change holds the level and clears the count
  a_r8_restart_holds: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (lvl_q == $past(lvl_q) && cnt_q == '0));

  // R4: no timer selected means straight copy of the input
  a_r4_passthrough: assert property (@(posedge clk) disable iff (rst)
    (!$past(restart) && $past(per_sel) == '0) |-> (lvl_q == $past(samp)));

  // R6: with a period above one, a change needs a steady input
  a_r6_steady_before_change: assert property (@(posedge clk) disable iff (rst)
    (!$past(restart) && $past(per_sel) > CNT_W'(1) && lvl_q != $past(lvl_q))
      |-> ($past(samp) == $past(prev_q)));
endmodule

// File: rtl/shared_debounce_bank.sv
module shared_debounce_bank
  import dbt_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int CNT_W       = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [PINS-1:0]   pin_raw,
  output logic [PINS-1:0]   pin_level
);
  logic [NUM_TIMERS-1:0][CNT_W-1:0] periods;
  logic [PINS-1:0] sel_hi, sel_lo, restart, samp;

  dbt_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (samp)
  );

  dbt_cfg_regs #(.PINS(PINS), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .periods (periods),
    .sel_hi  (sel_hi),
    .sel_lo  (sel_lo),
    .restart (restart)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    dbt_pin_filter #(.CNT_W(CNT_W)) u_flt (
      .clk     (clk),
      .rst     (rst),
      .samp    (samp[i]),
      .code    ({sel_hi[i], sel_lo[i]}),
      .periods (periods),
      .restart (restart[i]),
      .lvl     (pin_level[i])
    );
  end
endmodule

// File: tb/tb_shared_debounce_bank.sv
module tb_shared_debounce_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pin_raw = '0;
  logic [31:0] pin_level;

  int compared = 0;
  int mismatched = 0;
  string phase = "R1";

  always #10ns clk = ~clk;

  shared_debounce_bank dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_raw(pin_raw), .pin_level(pin_level)
  );

  // Behavioural reference: integer run lengths per pin
  logic [31:0] m_s1, m_s2, m_lvl, m_prev, m_hi, m_lo;
  longint m_run [32];
  longint m_per [3];

  always @(posedge clk) begin : model
    logic [31:0] cur, rs;
    longint p;
    int code;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_lvl = '0; m_prev = '0; m_hi = '0; m_lo = '0;
      for (int i = 0; i < 32; i++) m_run[i] = 0;
      for (int t = 0; t < 3; t++) m_per[t] = 0;
    end else begin
      cur = m_s2;
      rs = '0;
      if (cfg_we && cfg_addr == 3) rs = rs | (cfg_wdata ^ m_hi);
      if (cfg_we && cfg_addr == 4) rs = rs | (cfg_wdata ^ m_lo);
      for (int i = 0; i < 32; i++) begin
        code = (m_hi[i] ? 2 : 0) + (m_lo[i] ? 1 : 0);
        p = (code == 0) ? 0 : m_per[code-1];
        if (rs[i]) m_run[i] = 0;
        else if (p == 0) begin m_lvl[i] = cur[i]; m_run[i] = 0; end
        else if (cur[i] == m_lvl[i]) m_run[i] = 0;
        else begin
          m_run[i] = (cur[i] != m_prev[i]) ? 1 : m_run[i] + 1;
          if (m_run[i] >= p) begin m_lvl[i] = cur[i]; m_run[i] = 0; end
        end
      end
      if (cfg_we) begin
        if (cfg_addr < 3) m_per[cfg_addr] = cfg_wdata;
        else if (cfg_addr == 3) m_hi = cfg_wdata;
        else if (cfg_addr == 4) m_lo = cfg_wdata;
      end
      m_prev = cur;
      m_s2 = m_s1;
      m_s1 = pin_raw;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      compared++;
      if (pin_level !== m_lvl) begin
        mismatched++;
        $display("FAIL %s model compare: got %h expected %h at %0t", phase, pin_level, m_lvl, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    logic [31:0] v, w;
    v = 32'hA5A5_0F0F;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", pin_level, 32'h0);

    // R2: latency through synchronizer with filtering off
    phase = "R2";
    pin_raw = v;
    @(negedge clk);
    @(negedge clk); chk("R2", pin_level, 32'h0);
    @(negedge clk); chk("R2", pin_level, v);

    // R3/R9: timers 4,10,0; pins 0-7 code1, 8-15 code2, 16-23 code3, 24-31 code0
    phase = "R3";
    wr(3'd0, 32'd4); wr(3'd1, 32'd10); wr(3'd2, 32'd0);
    wr(3'd4, 32'h00FF_00FF); wr(3'd3, 32'h00FF_FF00);
    idle(4);
    chk("R3", pin_level, v);

    // R5: 3-cycle pulse filtered on timed pins, passed on others
    phase = "R5";
    @(negedge clk); pin_raw = ~v;
    idle(2);
    @(negedge clk); pin_raw = v;
    idle(8);
    chk("R5", pin_level, v);

    // R5/R3/R4: long hold, exact firing edges per group
    @(negedge clk); pin_raw = ~v;
    idle(5);
    chk("R5", {24'h0, pin_level[7:0]}, {24'h0, v[7:0]});
    @(negedge clk);
    chk("R5", {24'h0, pin_level[7:0]}, {24'h0, ~v[7:0]});
    chk("R4", {pin_level[31:16], 16'h0}, {~v[31:16], 16'h0});
    idle(5);
    chk("R3", {16'h0, pin_level[15:8], 8'h0}, {16'h0, v[15:8], 8'h0});
    @(negedge clk);
    chk("R3", pin_level, ~v);
    w = ~v;

    // R6: pulse train of 8-cycle pulses on 10-cycle pins
    phase = "R6";
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); pin_raw = w ^ 32'h0000_FF00;
      idle(7);
      @(negedge clk); pin_raw = w;
    end
    idle(12);
    chk("R6", pin_level, w);

    // R7: retune shared timer 1 to 2 cycles
    phase = "R7";
    wr(3'd0, 32'd2);
    @(negedge clk); pin_raw = w ^ 32'h0000_00FF;
    idle(2);
    @(negedge clk); pin_raw = w;
    @(negedge clk);
    chk("R7", {24'h0, pin_level[7:0]}, {24'h0, ~w[7:0]});
    idle(8);
    chk("R7", pin_level, w);

    // R8: code change mid-count holds the level for the write edge
    phase = "R8";
    wr(3'd0, 32'd4);
    @(negedge clk); pin_raw = w ^ 32'h0000_FF00;
    idle(6);
    cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 32'h00FF_0000;
    @(negedge clk); cfg_we = 1'b0;
    chk("R8", {16'h0, pin_level[15:8], 8'h0}, {16'h0, w[15:8], 8'h0});
    @(negedge clk);
    chk("R8", {16'h0, pin_level[15:8], 8'h0}, {16'h0, ~w[15:8], 8'h0});
    w = pin_raw;

    // R9: unmapped writes change nothing observable
    phase = "R9";
    wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    @(negedge clk); pin_raw = ~w;
    idle(2);
    @(negedge clk); pin_raw = w;
    idle(12);
    chk("R9", pin_level, w);

    // R7/R3: random mix of toggles and configuration writes
    phase = "R7";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if ($urandom % 6 == 0) pin_raw = pin_raw ^ (32'h1 << ($urandom % 32));
      if ($urandom % 40 == 0) begin
        cfg_we = 1'b1;
        cfg_addr = 3'($urandom % 8);
        cfg_wdata = (cfg_addr < 3) ? 32'($urandom % 7) : $urandom;
      end
    end
    @(negedge clk); cfg_we = 1'b0;
    idle(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule